// File: doc/BRIEF.md
# Oscillator Warm-Up Timer

This block holds the CPU in a waiting state after an oscillator has been started, until enough clock edges have gone by for the oscillator to settle. A warm-up begins on leaving reset and whenever the system asserts a start request, which it does when a low-power stop state ends or when the operating clock source changes. The block counts edges of one of two clocks, fast or slow. Both arrive as single-cycle tick enables in the system clock domain. The chosen ticks pass through a small selectable pre-divider and then into a 14-bit counter.

The upper bits of the count are compared against a programmable threshold. When they match, the warm-up ends. The block then issues a one-cycle completion interrupt and raises a level CPU-run enable, which stays high until the next warm-up begins. Software sets the source, the divide ratio, the count enable and the threshold through a two-entry write port.

Top module: `osc_warmup_timer`

## Requirements
- R1: During reset, cpuRun and irqDone are low. Reset loads the defaults: fast source, divide by 1, counting enabled and threshold 2. A warm-up starts by itself when reset is released. With a fast tick on every cycle, cpuRun rises on the 129th clock edge after release.
- R2: When wrEn is high, a write to wrAddr 0 sets the control fields: bit 0 selects the source (0 = fast, 1 = slow), bits 2:1 hold the divide select, and bit 3 is the count enable. A write to wrAddr 1 loads the 8-bit threshold. Both registers take their new value on the clock edge that samples the write.
- R3: With source select 0, only fastTick advances the warm-up. With source select 1, only slowTick advances it. Ticks on the other input have no effect.
- R4: With divide select d (0 to 3), the counter advances once for every 2^d selected ticks.
- R5: The counter clears when a warm-up starts. The warm-up completes on the edge after the counter reaches threshold×64, so it takes threshold×64 divided ticks plus one cycle. A threshold of 0 completes on the first edge after the start edge.
- R6: irqDone is high for exactly the one cycle in which cpuRun rises.
- R7: A startReq sampled at a clock edge clears cpuRun at that edge and begins a new warm-up. cpuRun otherwise stays high until such a request arrives.
- R8: While the count enable is 0, the count does not advance, the warm-up does not complete and cpuRun stays low. Setting the enable again resumes counting from the count that was held.
- R9: After completion, the counter stops at the match value. Further ticks produce no second interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fastTick | input | 1 | One-cycle tick per fast oscillator edge |
| slowTick | input | 1 | One-cycle tick per slow oscillator edge |
| startReq | input | 1 | Begin a new warm-up (stop release or clock switch) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 = control register, 1 = threshold register |
| wrData | input | 8 | Write data |
| irqDone | output | 1 | One-cycle completion interrupt |
| cpuRun | output | 1 | CPU-run enable, high after the warm-up completes |

## Verification
The hardest case to reach from the ports is a warm-up that starts while counting is disabled and is then resumed partway through. The stimulus starts a warm-up with the enable cleared and lets ticks run for several hundred cycles while confirming cpuRun stays low. It then sets the enable and measures the exact number of edges to completion, which is correct only if the held count was neither lost nor advanced. Source isolation is tested in the same way: ticks on the unselected input run for a long time, and then the completion latency from the first selected tick shows that the ignored ticks added nothing.

// File: rtl/warmup_pkg.sv
package warmup_pkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic clear;  // restart: zero pre-divider and counter
    logic run;    // warm-up active, enabled and not yet matched
  } wuStrobe_t;

  localparam int CTRL_SRC_BIT = 0;
  localparam int CTRL_DIV_LSB = 1;
  localparam int CTRL_EN_BIT  = 3;
endpackage

// File: rtl/warmup_datapath.sv
module warmup_datapath
  import warmup_pkg::*;
#(
  parameter int CNT_W      = 14,
  parameter int CMP_W      = 8,
  parameter int PRE_STAGES = 3,
  localparam int DIV_W     = $clog2(PRE_STAGES + 1),
  localparam int LOW_W     = CNT_W - CMP_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fastTick,
  input  logic             slowTick,
  input  logic             srcSel,
  input  logic [DIV_W-1:0] divSel,
  input  logic [CMP_W-1:0] cmpVal,
  input  wuStrobe_t        stb,
  output logic             match
);
  logic [PRE_STAGES-1:0] preCnt;
  logic [CNT_W-1:0]      cnt;
  logic [PRE_STAGES:0]   tapReady;
  logic                  selTick;
  logic                  divTick;

  assign selTick = srcSel ? slowTick : fastTick;

  // Tap k is ready when the low k pre-divider bits are all ones.
  assign tapReady[0] = 1'b1;
  for (genvar k = 1; k <= PRE_STAGES; k++) begin : g_tap
    assign tapReady[k] = &preCnt[k-1:0];
  end

  assign divTick = selTick && tapReady[divSel];
  assign match   = (cnt[CNT_W-1 -: CMP_W] == cmpVal) && (cnt[LOW_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      preCnt <= '0;
      cnt    <= '0;
    end else if (stb.run) begin
      if (selTick) preCnt <= preCnt + 1'b1;
      if (divTick) cnt    <= cnt + 1'b1;
    end
  end

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> cnt == '0);
  assert_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && divTick && !stb.clear) |=> cnt == $past(cnt) + 1'b1);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.run && !stb.clear) |=> $stable(cnt));
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && divTick) |-> cnt != '1);
endmodule

// File: rtl/warmup_ctrl.sv
module warmup_ctrl
  import warmup_pkg::*;
#(
  parameter int CMP_W      = 8,
  parameter int DIV_W      = 2,
  parameter int RST_CMP    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [CMP_W-1:0] wrData,
  input  logic             match,
  output logic             srcSel,
  output logic [DIV_W-1:0] divSel,
  output logic [CMP_W-1:0] cmpVal,
  output wuStrobe_t        stb,
  output logic             irqDone,
  output logic             cpuRun
);
  logic countEn;
  logic active;
  logic done;

  assign done      = active && countEn && match;
  assign stb.run   = active && countEn && !match;
  assign stb.clear = startReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel  <= 1'b0;
      divSel  <= '0;
      countEn <= 1'b1;
      cmpVal  <= CMP_W'(RST_CMP);
    end else if (wrEn) begin
      if (wrAddr) cmpVal <= wrData;
      else begin
        srcSel  <= wrData[CTRL_SRC_BIT];
        divSel  <= wrData[CTRL_DIV_LSB +: DIV_W];
        countEn <= wrData[CTRL_EN_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b1;
      cpuRun  <= 1'b0;
      irqDone <= 1'b0;
    end else begin
      irqDone <= 1'b0;
      if (startReq) begin
        active <= 1'b1;
        cpuRun <= 1'b0;
      end else if (done) begin
        active  <= 1'b0;
        cpuRun  <= 1'b1;
        irqDone <= 1'b1;
      end
    end
  end

  assert_rise_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuRun) |-> irqDone);
  assert_irq_run_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqDone |-> cpuRun);
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> !cpuRun);
  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (active && !countEn) |=> !irqDone);
endmodule

// File: rtl/osc_warmup_timer.sv
module osc_warmup_timer
  import warmup_pkg::*;
#(
  parameter int CNT_W      = 14,
  parameter int CMP_W      = 8,
  parameter int PRE_STAGES = 3,
  parameter int RST_CMP    = 2,
  localparam int DIV_W     = $clog2(PRE_STAGES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fastTick,
  input  logic             slowTick,
  input  logic             startReq,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [CMP_W-1:0] wrData,
  output logic             irqDone,
  output logic             cpuRun
);
  wuStrobe_t        stb;
  logic             match;
  logic             srcSel;
  logic [DIV_W-1:0] divSel;
  logic [CMP_W-1:0] cmpVal;

  warmup_ctrl #(.CMP_W(CMP_W), .DIV_W(DIV_W), .RST_CMP(RST_CMP)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .match(match), .srcSel(srcSel), .divSel(divSel),
    .cmpVal(cmpVal), .stb(stb), .irqDone(irqDone), .cpuRun(cpuRun)
  );

  warmup_datapath #(.CNT_W(CNT_W), .CMP_W(CMP_W), .PRE_STAGES(PRE_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .fastTick(fastTick), .slowTick(slowTick),
    .srcSel(srcSel), .divSel(divSel), .cmpVal(cmpVal), .stb(stb), .match(match)
  );
endmodule

// File: tb/osc_warmup_timer_bench.sv
`timescale 1ns/1ps
module osc_warmup_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fastTick = 1'b1;
  logic       slowTick = 1'b0;
  logic       startReq = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic       irqDone;
  logic       cpuRun;
  int         checks = 0;
  int         fails = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  osc_warmup_timer u_osc_warmup_timer (
    .clk(clk), .rstN(rstN), .fastTick(fastTick), .slowTick(slowTick),
    .startReq(startReq), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irqDone(irqDone), .cpuRun(cpuRun)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(bit addr, logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // ctrl byte: bit0 src, bits2:1 div, bit3 enable
  function automatic logic [7:0] ctrlByte(bit src, int div, bit en);
    return {4'b0, en, 2'(div), src};
  endfunction

  task automatic pulseStart();
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // Negedges counted until cpuRun is seen high; irqDone checked there and after.
  task automatic waitDone(string req, int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (cpuRun) break;
    end
    if (cpuRun) begin
      check({req, " irq with rise"}, int'(irqDone), 1);
      @(negedge clk);
      check({req, " irq one cycle"}, int'(irqDone), 0);
    end
  endtask

  task automatic runLatency(string req, bit src, int div, int thr, int expN);
    int n;
    writeReg(1'b1, 8'(thr));
    writeReg(1'b0, ctrlByte(src, div, 1'b1));
    pulseStart();
    check({req, " cpuRun cleared by start (R7)"}, int'(cpuRun), 0);
    waitDone(req, expN + 50, n);
    check({req, " latency"}, n, expN);
  endtask

  task automatic testReset();
    int n;
    repeat (3) @(negedge clk);
    check("R1 cpuRun in reset", int'(cpuRun), 0);
    check("R1 irqDone in reset", int'(irqDone), 0);
    rstN = 1'b1;
    waitDone("R1", 300, n);
    check("R1 auto warm-up latency", n, 129);
  endtask

  task automatic testDivider();
    runLatency("R4 div1", 1'b0, 0, 1, 65);
    runLatency("R4 div2", 1'b0, 1, 1, 129);
    runLatency("R4 div4", 1'b0, 2, 1, 257);
    runLatency("R4 div8", 1'b0, 3, 1, 513);
    runLatency("R2 R5 threshold 3", 1'b0, 0, 3, 193);
    runLatency("R5 threshold 0", 1'b0, 0, 0, 1);
  endtask

  task automatic testSource();
    int n;
    writeReg(1'b1, 8'd1);
    writeReg(1'b0, ctrlByte(1'b1, 0, 1'b1));
    fastTick = 1'b1; slowTick = 1'b0;
    pulseStart();
    repeat (200) @(negedge clk);
    check("R3 fast ignored when slow selected", int'(cpuRun), 0);
    slowTick = 1'b1; fastTick = 1'b0;
    waitDone("R3", 200, n);
    check("R3 slow source latency", n, 65);
    fastTick = 1'b1; slowTick = 1'b0;
  endtask

  task automatic testDisable();
    int n;
    writeReg(1'b1, 8'd1);
    writeReg(1'b0, ctrlByte(1'b0, 0, 1'b0));
    pulseStart();
    repeat (300) @(negedge clk);
    check("R8 no completion while disabled", int'(cpuRun), 0);
    writeReg(1'b0, ctrlByte(1'b0, 0, 1'b1));
    waitDone("R8", 200, n);
    check("R8 resume latency", n, 65);
  endtask

  task automatic testHold();
    int irqs = 0;
    bit dropped = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (irqDone) irqs++;
      if (!cpuRun) dropped = 1'b1;
    end
    check("R9 no second interrupt", irqs, 0);
    check("R7 cpuRun held high", int'(dropped), 0);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    testHold();
    testDivider();
    testHold();
    testSource();
    testDisable();
    testHold();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule